// File: doc/BRIEF.md
# Serial/JTAG Debug Port Mode Selector

This block sits on the target side of a two-wire debug port whose mode line is shared between a JTAG test-mode-select function and a serial-wire data function. On every rising edge of the debug clock it samples the shared line. It decides whether the port currently runs in JTAG mode or in serial-wire mode. It watches for a long run of high bits followed by a 16-bit mode-switch code sent least significant bit first. Both codes walk a legal JTAG TAP path, so the TAP that sits beside this block keeps following the line normally while the detector listens. This block only observes the line and never holds the TAP back.

After reset the port is in JTAG mode. In JTAG mode a run of at least `RUN_MIN` (default 50) consecutive highs followed by the code 0xE79E moves the port into serial-wire mode. In serial-wire mode the same kind of run followed by 0xE73C moves it back to JTAG. In serial-wire mode the `RUN_MIN`-th consecutive high also raises a one-cycle line-reset pulse. The TAP registers, serial-wire packet decoding and access-port logic live outside this block.

The detector is a three-state machine:
- `SEEK_WAIT` is the idle state. It moves to `SEEK_PRIMED` on the clock that completes a saturated high run (arm).
- `SEEK_PRIMED` stays in place while the line stays high. On a low bit it moves to `SEEK_SHIFT` (start), because both codes begin with a 0.
- `SEEK_SHIFT` compares each bit against the expected code. On a wrong bit it returns to `SEEK_WAIT` (abort). When the sixteenth bit matches the shift window, it returns to `SEEK_WAIT` and toggles the mode (fire).

Top module: `swj_mode_sel`

## Requirements
- R1: While reset is asserted and on the first clock after its release, `mode_swd` is 0 (JTAG), and `switch_pulse` and `line_reset_pulse` are 0.
- R2: In JTAG mode, at least 50 consecutive high samples followed at once by 0xE79E sent LSB first (0,1,1,1,1,0,0,1,1,1,1,0,0,1,1,1) set `mode_swd` to 1. This happens on the edge that samples the last code bit, and `switch_pulse` is 1 for that cycle.
- R3: A high run of only 49 samples before the code does not change the mode.
- R4: A code with any wrong bit does not switch the port and disarms the detector. A correct code sent straight after the wrong one, with no new run of at least 50 highs, does not switch either.
- R5: The high-run count saturates: a run of any length of at least 50 (for example 300) still arms the switch.
- R6: In serial-wire mode, `line_reset_pulse` is 1 for exactly one cycle, after the edge that samples the 50th consecutive high of a run. The line staying high longer gives no further pulse, and in JTAG mode no pulse is ever produced.
- R7: In serial-wire mode, at least 50 consecutive highs followed by 0xE73C sent LSB first set `mode_swd` to 0, with a one-cycle `switch_pulse`.
- R8: Only the code for the other mode is recognised: 0xE79E in serial-wire mode and 0xE73C in JTAG mode leave the mode unchanged.
- R9: `switch_pulse` is one cycle wide, and `mode_swd` changes only in a cycle where `switch_pulse` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Shared mode-select / serial data line |
| mode_swd | output | 1 | 0 = JTAG mode, 1 = serial-wire mode |
| switch_pulse | output | 1 | One-cycle pulse when the mode toggles |
| line_reset_pulse | output | 1 | One-cycle serial-wire line-reset pulse |

## Verification
Every result is registered once. The mode, the switch pulse and the line-reset pulse all appear after the rising edge that samples the bit deciding them, so each one is due one sample after that bit, with no further delay. The bench drives each bit on a falling edge, lets one rising edge pass, and compares all three outputs on the following falling edge against a history-based model. That model is stepped with the same bit. Directed sequences cover the 49/50 run boundary, corrupted and wrong-mode codes, and long saturated runs, and a seeded random mix of these patterns follows them.

// File: rtl/swj_pkg.sv
package swj_pkg;
    localparam int unsigned CODE_W = 16;
    localparam logic [CODE_W-1:0] DEF_CODE_TO_SWD  = 16'hE79E;
    localparam logic [CODE_W-1:0] DEF_CODE_TO_JTAG = 16'hE73C;

    typedef enum logic [1:0] {
        SEEK_WAIT   = 2'd0,
        SEEK_PRIMED = 2'd1,
        SEEK_SHIFT  = 2'd2
    } seek_state_t;
endpackage

// File: rtl/swj_run_counter.sv
module swj_run_counter #(
    parameter int unsigned RUN_MIN = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic run_sat_next,
    output logic run_hit_next
);
    localparam int unsigned CW = $clog2(RUN_MIN + 1);
    localparam logic [CW-1:0] FULL = CW'(RUN_MIN);
    localparam logic [CW-1:0] LAST = CW'(RUN_MIN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!line_in)
            cnt <= '0;
        else if (cnt != FULL)
            cnt <= cnt + 1'b1;
    end

    // This sample completes (or extends) a saturated high run.
    assign run_sat_next = line_in && (cnt >= LAST);
    // This sample is exactly the RUN_MIN-th consecutive high.
    assign run_hit_next = line_in && (cnt == LAST);

    assert_run_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);

    assert_hit_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_hit_next |=> !run_hit_next);
endmodule

// File: rtl/swj_code_seeker.sv
module swj_code_seeker
    import swj_pkg::*;
#(
    parameter logic [CODE_W-1:0] CODE_TO_SWD  = DEF_CODE_TO_SWD,
    parameter logic [CODE_W-1:0] CODE_TO_JTAG = DEF_CODE_TO_JTAG
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic run_sat_next,
    input  logic mode_swd,
    output logic code_done
);
    localparam int unsigned IW = $clog2(CODE_W);
    localparam logic [IW-1:0] IDX_LAST = IW'(CODE_W - 1);

    seek_state_t       st, st_nx;
    logic [IW-1:0]     idx, idx_nx;
    logic [CODE_W-1:0] win;
    logic [CODE_W-1:0] want;

    assign want = mode_swd ? CODE_TO_JTAG : CODE_TO_SWD;

    // State register and shift window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= SEEK_WAIT;
            idx <= '0;
            win <= '0;
        end else begin
            st  <= st_nx;
            idx <= idx_nx;
            win <= {line_in, win[CODE_W-1:1]};
        end
    end

    // Next-state logic
    always_comb begin
        st_nx  = st;
        idx_nx = idx;
        unique case (st)
            SEEK_WAIT: begin
                if (run_sat_next)
                    st_nx = SEEK_PRIMED;
            end
            SEEK_PRIMED: begin
                if (!line_in) begin
                    if (!want[0]) begin
                        st_nx  = SEEK_SHIFT;
                        idx_nx = IW'(1);
                    end else begin
                        st_nx = SEEK_WAIT;
                    end
                end
            end
            SEEK_SHIFT: begin
                if (line_in != want[idx])
                    st_nx = SEEK_WAIT;
                else if (idx == IDX_LAST)
                    st_nx = SEEK_WAIT;
                else
                    idx_nx = idx + 1'b1;
            end
            default: st_nx = SEEK_WAIT;
        endcase
    end

    // Output logic
    always_comb begin
        code_done = (st == SEEK_SHIFT) && (idx == IDX_LAST) &&
                    ({line_in, win[CODE_W-1:1]} == want);
    end

    assert_primed_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEEK_PRIMED) |-> ($past(st) == SEEK_PRIMED) || $past(run_sat_next));

    assert_done_from_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        code_done |-> $past(st) == SEEK_SHIFT);
endmodule

// File: rtl/swj_mode_sel.sv
module swj_mode_sel
    import swj_pkg::*;
#(
    parameter int unsigned       RUN_MIN      = 50,
    parameter logic [CODE_W-1:0] CODE_TO_SWD  = DEF_CODE_TO_SWD,
    parameter logic [CODE_W-1:0] CODE_TO_JTAG = DEF_CODE_TO_JTAG
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic mode_swd,
    output logic switch_pulse,
    output logic line_reset_pulse
);
    logic run_sat_next;
    logic run_hit_next;
    logic code_done;

    swj_run_counter #(.RUN_MIN(RUN_MIN)) u_run (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_in      (line_in),
        .run_sat_next (run_sat_next),
        .run_hit_next (run_hit_next)
    );

    swj_code_seeker #(
        .CODE_TO_SWD  (CODE_TO_SWD),
        .CODE_TO_JTAG (CODE_TO_JTAG)
    ) u_seek (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_in      (line_in),
        .run_sat_next (run_sat_next),
        .mode_swd     (mode_swd),
        .code_done    (code_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_swd         <= 1'b0;
            switch_pulse     <= 1'b0;
            line_reset_pulse <= 1'b0;
        end else begin
            mode_swd         <= mode_swd ^ code_done;
            switch_pulse     <= code_done;
            line_reset_pulse <= mode_swd && run_hit_next;
        end
    end

    assert_mode_with_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_swd != $past(mode_swd)) |-> switch_pulse);

    assert_switch_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        switch_pulse |=> !switch_pulse);

    assert_lreset_swd_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_reset_pulse |-> (mode_swd && $past(mode_swd)));

    assert_switch_last_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        switch_pulse |-> $past(line_in));
endmodule

// File: tb/sim_swj_mode_sel.sv
`timescale 1ns/1ps
module sim_swj_mode_sel;
    localparam int RUN = 50;
    localparam logic [15:0] TO_SWD  = 16'hE79E;
    localparam logic [15:0] TO_JTAG = 16'hE73C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_in = 1'b1;
    logic mode_swd, switch_pulse, line_reset_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [65:0] hist = '0;
    int          ones = 0;
    logic        m_mode = 1'b0;
    int          lr_cnt = 0;
    int          sw_cnt = 0;

    always #5 clk = ~clk;

    swj_mode_sel u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .mode_swd(mode_swd), .switch_pulse(switch_pulse),
        .line_reset_pulse(line_reset_pulse)
    );

    function automatic logic code_seen(input logic [65:0] h, input logic [15:0] c);
        for (int j = 0; j < 16; j++)
            if (h[j] != c[15-j]) return 1'b0;
        for (int j = 16; j < 66; j++)
            if (!h[j]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [15:0] flip_bit(input logic [15:0] c, input int pos);
        logic [15:0] r = c;
        r[pos] = ~r[pos];
        return r;
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic b, input string tag);
        logic pm, e_sw, e_lr;
        line_in = b;
        @(posedge clk);
        @(negedge clk);
        pm   = m_mode;
        hist = {hist[64:0], b};
        ones = b ? ones + 1 : 0;
        e_lr = pm && (ones == RUN);
        e_sw = code_seen(hist, pm ? TO_JTAG : TO_SWD);
        if (e_sw) m_mode = ~pm;
        if (line_reset_pulse) lr_cnt++;
        if (switch_pulse) sw_cnt++;
        chk(switch_pulse, e_sw, tag, "switch_pulse");
        chk(mode_swd, m_mode, tag, "mode_swd");
        chk(line_reset_pulse, e_lr, tag, "line_reset_pulse");
    endtask

    task automatic send_ones(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, tag);
    endtask

    task automatic send_code(input logic [15:0] c, input string tag);
        for (int i = 0; i < 16; i++) step(c[i], tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(mode_swd, 1'b0, "R1", "mode in reset");
        chk(switch_pulse, 1'b0, "R1", "switch in reset");
        chk(line_reset_pulse, 1'b0, "R1", "lreset in reset");
        rst_n = 1'b1;
        step(1'b0, "R1");

        // R3: 49 highs are not enough
        send_ones(49, "R3");
        send_code(TO_SWD, "R3");
        chk(mode_swd, 1'b0, "R3", "mode after short run");

        // R2: 50 highs then the code switches to serial-wire
        step(1'b0, "R2");
        sw_cnt = 0;
        lr_cnt = 0;
        send_ones(50, "R6");
        chk(1'(lr_cnt != 0), 1'b0, "R6", "no lreset in JTAG");
        send_code(TO_SWD, "R2");
        chk(mode_swd, 1'b1, "R2", "mode after switch");
        step(1'b1, "R9");
        chk(switch_pulse, 1'b0, "R9", "pulse width");
        chk(1'(sw_cnt == 1), 1'b1, "R9", "one switch pulse");

        // R8: the JTAG-to-serial code is ignored in serial-wire mode
        step(1'b0, "R8");
        send_ones(50, "R8");
        send_code(TO_SWD, "R8");
        chk(mode_swd, 1'b1, "R8", "mode unchanged");

        // R6: one line reset per long run
        step(1'b0, "R6");
        lr_cnt = 0;
        send_ones(120, "R6");
        chk(1'(lr_cnt == 1), 1'b1, "R6", "single line reset");

        // R7: back to JTAG
        send_code(TO_JTAG, "R7");
        chk(mode_swd, 1'b0, "R7", "mode after return");

        // R8: the return code is ignored in JTAG mode
        step(1'b0, "R8");
        send_ones(60, "R8");
        send_code(TO_JTAG, "R8");
        chk(mode_swd, 1'b0, "R8", "JTAG keeps mode");

        // R4: a corrupted code disarms the detector
        step(1'b0, "R4");
        send_ones(60, "R4");
        send_code(flip_bit(TO_SWD, 7), "R4");
        send_code(TO_SWD, "R4");
        chk(mode_swd, 1'b0, "R4", "no switch without new run");

        // R5: a very long run still arms
        step(1'b0, "R5");
        send_ones(300, "R5");
        send_code(TO_SWD, "R5");
        chk(mode_swd, 1'b1, "R5", "switch after long run");

        // Random mix
        for (int ep = 0; ep < 400; ep++) begin
            int kind = int'($urandom_range(0, 5));
            int len  = int'($urandom_range(44, 70));
            case (kind)
                0: begin send_ones(len, "R2/R7"); send_code(m_mode ? TO_JTAG : TO_SWD, "R2/R7"); end
                1: begin send_ones(len, "R4"); send_code(flip_bit(m_mode ? TO_JTAG : TO_SWD, int'($urandom_range(0, 15))), "R4"); end
                2: for (int i = 0; i < 20; i++) step(1'($urandom_range(0, 1)), "R9");
                3: begin send_ones(len, "R8"); send_code(m_mode ? TO_SWD : TO_JTAG, "R8"); end
                4: begin send_ones(len, "R6"); step(1'b0, "R6"); end
                default: begin step(1'b0, "R3"); send_ones(int'($urandom_range(47, 52)), "R3"); send_code(m_mode ? TO_JTAG : TO_SWD, "R3"); end
            endcase
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule